// File: doc/BRIEF.md
# Windowed Packet Buffer Access Port

This block lets a host CPU reach a byte-wide packet RAM through one data window. Two independent pointers decide where window traffic lands. Stores go to the address in the write pointer, and loads come from the address in the read pointer. The RAM is split into a receive region and a transmit region. Those regions are defined only by the programmable receive-start and receive-end registers, together with the way software places the write pointer. Nothing in the access path depends on the state of a network engine, so the RAM can be used as general storage with the engine powered down.

When auto-increment is enabled, each access advances the pointer it used. Reads follow a circular rule inside the receive region: a read at the receive-end address sends the read pointer back to the receive start. Writes move forward in a straight line and wrap only at the top of the RAM. A write marked as a single-cycle read-modify-write style access has a side effect: it also advances the read pointer. A request that asks for a read and a write of the window in the same cycle is refused and flagged as an error.

The RAM holds 2**AddrW bytes. AddrW = 13 gives the full 8 KB, with 13-bit pointers. The default is kept smaller so that elaboration stays light.

Top module: `pkt_window_port`

## Requirements
- R1: After reset: read pointer = 0, write pointer = 0, receive start = 0, receive end = all ones, auto-increment enabled, rdValid = 0, accErr = 0.
- R2: A window write (winWr=1, winRd=0) stores wrData at the address in the write pointer. A window read (winRd=1, winWr=0) places the byte at the read-pointer address on rdData, with rdValid=1, one clock after the strobe.
- R3: With auto-increment enabled, the pointer used by an access changes on the same edge that completes the access. With auto-increment disabled, neither pointer moves on an access.
- R4: A read with auto-increment enabled, made while the read pointer equals the receive-end register, loads the read pointer from the receive-start register. At any other address the read pointer goes up by one.
- R5: The write pointer never wraps at the receive end. It goes up by one modulo 2**AddrW, so it goes from all ones to 0.
- R6: A write with wrRmw=1 and auto-increment enabled also steps the read pointer, following the R4 rule, without asserting rdValid. A write with wrRmw=0 leaves the read pointer unchanged.
- R7: When winRd and winWr are both 1 in the same cycle, the RAM is not written, neither pointer moves, rdValid stays 0, and accErr is 1 for exactly the following cycle.
- R8: ptrLd loads ptrData into the register chosen by ptrSel (0 = read pointer, 1 = write pointer, 2 = receive start, 3 = receive end). A load wins over an auto-increment of the same pointer in the same cycle, and a read in that cycle still uses the old pointer.
- R9: cfgWr writes cfgAutoInc into the auto-increment enable. An access in the same cycle uses the previous setting. With no access and no load, both pointers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winRd | input | 1 | Read strobe for the data window |
| winWr | input | 1 | Write strobe for the data window |
| wrRmw | input | 1 | Marks a window write as read-modify-write style |
| wrData | input | DataW | Byte to store |
| ptrLd | input | 1 | Load strobe for a pointer register |
| ptrSel | input | 2 | Selects the register to load |
| ptrData | input | AddrW | Value to load |
| cfgWr | input | 1 | Write strobe for the auto-increment enable |
| cfgAutoInc | input | 1 | New auto-increment setting |
| rdData | output | DataW | Registered data from a window read |
| rdValid | output | 1 | rdData was updated on the last edge |
| accErr | output | 1 | The last cycle had a read/write clash |
| rdPtr | output | AddrW | Current read pointer |
| wrPtr | output | AddrW | Current write pointer |

## Verification
The bench places a short receive region in the middle of the RAM. It then reads across the receive-end address and checks that the read pointer returns to the receive start. A design that only counted upward would read stale transmit bytes at this point. Writes are pushed across the same boundary and across the top of the RAM, which catches a write pointer that wraps like the read pointer. Read-modify-write style writes are issued at the receive end, so a design that ignores the read-pointer side effect, or that steps it without the wrap rule, shows the wrong pointer. Read/write clashes, loads that coincide with a read, and a configuration change made during an access are aimed at designs that corrupt RAM on a clash, let the increment beat the load, or apply the new setting one cycle too early.

// File: rtl/winport_pkg.sv
package winport_pkg;

  // Register selector codes for host pointer loads
  localparam logic [1:0] SelRdPtr   = 2'd0;
  localparam logic [1:0] SelWrPtr   = 2'd1;
  localparam logic [1:0] SelRxStart = 2'd2;
  localparam logic [1:0] SelRxEnd   = 2'd3;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic doRd;     // perform a window read
    logic doWr;     // perform a window write
    logic incRd;    // step read pointer (wrap rule applies)
    logic incWr;    // step write pointer (linear)
    logic ldRd;     // host load of read pointer
    logic ldWr;     // host load of write pointer
    logic ldRxSt;   // host load of receive start
    logic ldRxEnd;  // host load of receive end
    logic clash;    // read and write requested together
  } winStrobe_t;

endpackage

// File: rtl/winport_ctrl.sv
module winport_ctrl
  import winport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       winRd,
  input  logic       winWr,
  input  logic       wrRmw,
  input  logic       ptrLd,
  input  logic [1:0] ptrSel,
  input  logic       cfgWr,
  input  logic       cfgAutoInc,
  output winStrobe_t st
);

  logic       autoInc;
  logic [3:0] ldHot;

  always_ff @(posedge clk) begin
    if (!rstN) autoInc <= 1'b1;
    else if (cfgWr) autoInc <= cfgAutoInc;
  end

  // One-hot decode of the load target
  for (genvar i = 0; i < 4; i++) begin : g_ldDec
    assign ldHot[i] = ptrLd && (ptrSel == 2'(i));
  end

  always_comb begin
    st         = '0;
    st.clash   = winRd && winWr;
    st.doRd    = winRd && !winWr;
    st.doWr    = winWr && !winRd;
    st.incWr   = autoInc && st.doWr;
    // a read, or an RMW-style write, moves the read pointer
    st.incRd   = autoInc && (st.doRd || (st.doWr && wrRmw));
    st.ldRd    = ldHot[SelRdPtr];
    st.ldWr    = ldHot[SelWrPtr];
    st.ldRxSt  = ldHot[SelRxStart];
    st.ldRxEnd = ldHot[SelRxEnd];
  end

  // R9: the enable changes only through its write strobe
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable(autoInc));

  // R9: a configuration write lands on the next edge
  a_r9_cfg_take: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (autoInc == $past(cfgAutoInc)));

endmodule

// File: rtl/winport_dp.sv
module winport_dp
  import winport_pkg::*;
#(
  parameter int unsigned AddrW = 11,
  parameter int unsigned DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       st,
  input  logic [AddrW-1:0] ptrData,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic             rdValid,
  output logic             accErr,
  output logic [AddrW-1:0] rdPtr,
  output logic [AddrW-1:0] wrPtr
);

  localparam int unsigned    Depth = 1 << AddrW;
  localparam logic [AddrW-1:0] One = AddrW'(1);

  logic [DataW-1:0] mem [Depth];
  logic [AddrW-1:0] rxStart;
  logic [AddrW-1:0] rxEnd;
  logic [AddrW-1:0] rdNext;
  logic [AddrW-1:0] wrNext;

  // circular step inside receive region; linear step for writes
  assign rdNext = (rdPtr == rxEnd) ? rxStart : rdPtr + One;
  assign wrNext = wrPtr + One;

  always_ff @(posedge clk) begin
    if (st.doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      accErr  <= 1'b0;
    end else begin
      rdValid <= st.doRd;
      accErr  <= st.clash;
      if (st.doRd) rdData <= mem[rdPtr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr   <= '0;
      wrPtr   <= '0;
      rxStart <= '0;
      rxEnd   <= '1;
    end else begin
      if (st.ldRd)       rdPtr <= ptrData;
      else if (st.incRd) rdPtr <= rdNext;
      if (st.ldWr)       wrPtr <= ptrData;
      else if (st.incWr) wrPtr <= wrNext;
      if (st.ldRxSt)     rxStart <= ptrData;
      if (st.ldRxEnd)    rxEnd   <= ptrData;
    end
  end

  // R4: stepping from the receive end returns to the receive start
  a_r4_rd_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (st.incRd && !st.ldRd && (rdPtr == rxEnd)) |=> (rdPtr == $past(rxStart)));

  // R5: write pointer advances linearly, never wraps into the region
  a_r5_wr_linear: assert property (@(posedge clk) disable iff (!rstN)
    (st.incWr && !st.ldWr) |=> (wrPtr == AddrW'($past(wrPtr) + One)));

  // R7: a clash moves no pointer
  a_r7_clash_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (st.clash && !st.ldRd && !st.ldWr) |=> ($stable(rdPtr) && $stable(wrPtr)));

  // R7: error and valid never coincide
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> !rdValid);

  // R8: host load beats increment
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    st.ldRd |=> (rdPtr == $past(ptrData)));

  // R2: read data valid one clock after a read
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    st.doRd |=> rdValid);

endmodule

// File: rtl/pkt_window_port.sv
module pkt_window_port
  import winport_pkg::*;
#(
  parameter int unsigned AddrW = 11,
  parameter int unsigned DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             winRd,
  input  logic             winWr,
  input  logic             wrRmw,
  input  logic [DataW-1:0] wrData,
  input  logic             ptrLd,
  input  logic [1:0]       ptrSel,
  input  logic [AddrW-1:0] ptrData,
  input  logic             cfgWr,
  input  logic             cfgAutoInc,
  output logic [DataW-1:0] rdData,
  output logic             rdValid,
  output logic             accErr,
  output logic [AddrW-1:0] rdPtr,
  output logic [AddrW-1:0] wrPtr
);

  winStrobe_t st;

  winport_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .winRd      (winRd),
    .winWr      (winWr),
    .wrRmw      (wrRmw),
    .ptrLd      (ptrLd),
    .ptrSel     (ptrSel),
    .cfgWr      (cfgWr),
    .cfgAutoInc (cfgAutoInc),
    .st         (st)
  );

  winport_dp #(.AddrW(AddrW), .DataW(DataW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .ptrData (ptrData),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .accErr  (accErr),
    .rdPtr   (rdPtr),
    .wrPtr   (wrPtr)
  );

  // R7: a clash at the ports is flagged on the next cycle
  a_r7_clash_flag: assert property (@(posedge clk) disable iff (!rstN)
    (winRd && winWr) |=> (accErr && !rdValid));

  // R6: a plain write leaves the read pointer alone
  a_r6_plain_wr: assert property (@(posedge clk) disable iff (!rstN)
    (winWr && !winRd && !wrRmw && !ptrLd) |=> $stable(rdPtr));

endmodule

// File: tb/sim_pkt_window_port.sv
`timescale 1ns/1ps
module sim_pkt_window_port;

  localparam int AW = 11;

  typedef struct packed {
    logic [2:0]    op;   // 0 idle,1 wr,2 rmw wr,3 rd,4 load,5 cfg
    logic [1:0]    sel;
    logic [AW-1:0] arg;
    logic [7:0]    wd;
    logic [AW-1:0] eRd;
    logic [AW-1:0] eWr;
    logic          chk;
    logic [7:0]    eData;
  } vec_t;

  localparam vec_t VECS[21] = '{
    '{3'd4, 2'd2, 11'h010, 8'h00, 11'h000, 11'h000, 1'b0, 8'h00}, // R8 rxStart
    '{3'd4, 2'd3, 11'h013, 8'h00, 11'h000, 11'h000, 1'b0, 8'h00}, // R8 rxEnd
    '{3'd4, 2'd1, 11'h010, 8'h00, 11'h000, 11'h010, 1'b0, 8'h00}, // R8 wrPtr
    '{3'd1, 2'd0, 11'h000, 8'hA1, 11'h000, 11'h011, 1'b0, 8'h00}, // R2 R3
    '{3'd1, 2'd0, 11'h000, 8'hA2, 11'h000, 11'h012, 1'b0, 8'h00},
    '{3'd1, 2'd0, 11'h000, 8'hA3, 11'h000, 11'h013, 1'b0, 8'h00},
    '{3'd1, 2'd0, 11'h000, 8'hA4, 11'h000, 11'h014, 1'b0, 8'h00}, // R5 past rxEnd
    '{3'd4, 2'd0, 11'h012, 8'h00, 11'h012, 11'h014, 1'b0, 8'h00},
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h013, 11'h014, 1'b1, 8'hA3}, // R2
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h010, 11'h014, 1'b1, 8'hA4}, // R4 wrap
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h011, 11'h014, 1'b1, 8'hA1},
    '{3'd5, 2'd0, 11'h000, 8'h00, 11'h011, 11'h014, 1'b0, 8'h00}, // R9 off
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h011, 11'h014, 1'b1, 8'hA2}, // R3 hold
    '{3'd1, 2'd0, 11'h000, 8'h55, 11'h011, 11'h014, 1'b0, 8'h00}, // R3 hold
    '{3'd5, 2'd0, 11'h001, 8'h00, 11'h011, 11'h014, 1'b0, 8'h00}, // R9 on
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h012, 11'h014, 1'b1, 8'hA2},
    '{3'd2, 2'd0, 11'h000, 8'h66, 11'h013, 11'h015, 1'b0, 8'h00}, // R6
    '{3'd2, 2'd0, 11'h000, 8'h77, 11'h010, 11'h016, 1'b0, 8'h00}, // R6 wrap
    '{3'd1, 2'd0, 11'h000, 8'h88, 11'h010, 11'h017, 1'b0, 8'h00}, // R6 plain
    '{3'd4, 2'd0, 11'h014, 8'h00, 11'h014, 11'h017, 1'b0, 8'h00},
    '{3'd3, 2'd0, 11'h000, 8'h00, 11'h015, 11'h017, 1'b1, 8'h66}  // R2
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          winRd = 0, winWr = 0, wrRmw = 0, ptrLd = 0, cfgWr = 0, cfgAutoInc = 0;
  logic [7:0]    wrData = '0;
  logic [1:0]    ptrSel = '0;
  logic [AW-1:0] ptrData = '0;
  logic [7:0]    rdData;
  logic          rdValid, accErr;
  logic [AW-1:0] rdPtr, wrPtr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  pkt_window_port #(.AddrW(AW), .DataW(8)) u0 (
    .clk(clk), .rstN(rstN), .winRd(winRd), .winWr(winWr), .wrRmw(wrRmw),
    .wrData(wrData), .ptrLd(ptrLd), .ptrSel(ptrSel), .ptrData(ptrData),
    .cfgWr(cfgWr), .cfgAutoInc(cfgAutoInc), .rdData(rdData), .rdValid(rdValid),
    .accErr(accErr), .rdPtr(rdPtr), .wrPtr(wrPtr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    winRd = 0; winWr = 0; wrRmw = 0; ptrLd = 0; cfgWr = 0;
  endtask

  // drive one op for one cycle; return at next negedge with outputs settled
  task automatic doOp(input logic [2:0] op, input logic [1:0] sel,
                      input logic [AW-1:0] arg, input logic [7:0] wd);
    @(negedge clk);
    clearIn();
    case (op)
      3'd1: begin winWr = 1; wrData = wd; end
      3'd2: begin winWr = 1; wrRmw = 1; wrData = wd; end
      3'd3: winRd = 1;
      3'd4: begin ptrLd = 1; ptrSel = sel; ptrData = arg; end
      3'd5: begin cfgWr = 1; cfgAutoInc = arg[0]; end
      default: ;
    endcase
    @(negedge clk);
    clearIn();
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1", "rdPtr", int'(rdPtr), 0);
    check("R1", "wrPtr", int'(wrPtr), 0);
    check("R1", "rdValid", int'(rdValid), 0);
    check("R1", "accErr", int'(accErr), 0);

    // table walk
    for (int i = 0; i < 21; i++) begin
      doOp(VECS[i].op, VECS[i].sel, VECS[i].arg, VECS[i].wd);
      check("R3/R4/R5/R6", $sformatf("vec%0d rdPtr", i), int'(rdPtr), int'(VECS[i].eRd));
      check("R3/R5/R6", $sformatf("vec%0d wrPtr", i), int'(wrPtr), int'(VECS[i].eWr));
      check("R2", $sformatf("vec%0d rdValid", i), int'(rdValid), int'(VECS[i].chk));
      if (VECS[i].chk) check("R2", $sformatf("vec%0d rdData", i), int'(rdData), int'(VECS[i].eData));
    end

    // R7 clash: wrPtr at 0x016 holds 0x88
    doOp(3'd4, 2'd1, 11'h016, 8'h00);
    @(negedge clk);
    winRd = 1; winWr = 1; wrData = 8'hEE;
    @(negedge clk);
    clearIn();
    check("R7", "accErr", int'(accErr), 1);
    check("R7", "rdValid", int'(rdValid), 0);
    check("R7", "wrPtr", int'(wrPtr), 'h016);
    check("R7", "rdPtr", int'(rdPtr), 'h015);
    @(negedge clk);
    check("R7", "accErr drop", int'(accErr), 0);
    doOp(3'd4, 2'd0, 11'h016, 8'h00);
    doOp(3'd3, 2'd0, 11'h000, 8'h00);
    check("R7", "ram untouched", int'(rdData), 'h88);

    // R5 top-of-RAM wrap of write pointer
    doOp(3'd4, 2'd1, 11'h7FF, 8'h00);
    doOp(3'd1, 2'd0, 11'h000, 8'h3C);
    check("R5", "wrPtr top wrap", int'(wrPtr), 0);
    doOp(3'd4, 2'd0, 11'h7FF, 8'h00);
    doOp(3'd3, 2'd0, 11'h000, 8'h00);
    check("R5", "top data", int'(rdData), 'h3C);
    check("R4", "rdPtr top step", int'(rdPtr), 0);

    // R8 load coinciding with a read
    doOp(3'd4, 2'd0, 11'h010, 8'h00);
    @(negedge clk);
    winRd = 1; ptrLd = 1; ptrSel = 2'd0; ptrData = 11'h100;
    @(negedge clk);
    clearIn();
    check("R8", "load wins", int'(rdPtr), 'h100);
    check("R8", "old ptr read", int'(rdData), 'hA1);

    // R9 config change during an access uses old setting
    @(negedge clk);
    winRd = 1; cfgWr = 1; cfgAutoInc = 0;
    @(negedge clk);
    clearIn();
    check("R9", "old setting", int'(rdPtr), 'h101);
    doOp(3'd3, 2'd0, 11'h000, 8'h00);
    check("R9", "new setting", int'(rdPtr), 'h101);
    doOp(3'd0, 2'd0, 11'h000, 8'h00);
    check("R9", "idle hold rd", int'(rdPtr), 'h101);
    check("R9", "idle hold wr", int'(wrPtr), 0);

    // R1 defaults after a second reset: auto-increment on, rxEnd all ones
    doReset();
    doOp(3'd1, 2'd0, 11'h000, 8'h5A);
    check("R1", "autoInc default", int'(wrPtr), 1);
    doOp(3'd4, 2'd0, 11'h7FF, 8'h00);
    doOp(3'd3, 2'd0, 11'h000, 8'h00);
    check("R1", "rxEnd default wrap", int'(rdPtr), 0);
    doOp(3'd3, 2'd0, 11'h000, 8'h00);
    check("R1", "read after reset", int'(rdData), 'h5A);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule